// File: doc/BRIEF.md
# Loop Phase-Frequency Detector with Lock Flag

This block compares two pulse trains for one synthesizer loop: the divided reference pulse and the divided oscillator (feedback) pulse. The difference in arrival time drives a three-state error output. That output is modelled as an output-enable plus a data bit. It drives high when the feedback edge comes late, drives low when it comes early, and floats when the two edges arrive together. An optional lock monitor watches the width of each error pulse. It raises an out-of-lock flag until enough consecutive comparisons fall within a small tolerance.

A per-loop power-down input stops the detector and lock monitor and clears their state. A status output serves two roles. In normal mode it shows the power-save level, so it can switch an external supply. In test mode it shows the divided channel-counter pulse instead.

Both pulse inputs are taken as synchronous to the block clock. Their rising edges are the events that get compared.

Top module: `loop_phase_det`

## Requirements
- R1: During and directly after reset, `err_oe` is 0 and `out_of_lock` is 1.
- R2: A rising edge on `ref_in` that comes k cycles (k ≥ 1) before a rising edge on `fb_in` gives `err_oe`=1 with `err_val`=1 for exactly k cycles. The pulse starts in the cycle after the reference edge.
- R3: A rising edge on `fb_in` that comes k cycles (k ≥ 1) before a rising edge on `ref_in` gives `err_oe`=1 with `err_val`=0 for exactly k cycles. The pulse starts in the cycle after the feedback edge.
- R4: Rising edges on both inputs in the same cycle, with no pulse pending, leave `err_oe` at 0 (high-impedance).
- R5: With `LOCK_EN`=1, `out_of_lock` falls to 0 in the cycle after the `LOCK_RUN`-th consecutive comparison whose error is at most `LOCK_TOL` cycles (defaults 4 and 1). A comparison's error is its pulse width, and 0 for coincident edges.
- R6: While locked, a single comparison with an error above `LOCK_TOL` sets `out_of_lock` to 1 in the cycle after that comparison completes.
- R7: While `pwr_down` is 1, `err_oe` is 0 from the next cycle on, any pending pulse is cleared, and `out_of_lock` is 1. Edges that arrive during power-down leave no pulse after release.
- R8: With `test_mode`=0, `ps_stat` equals `pwr_down`.
- R9: With `test_mode`=1, `ps_stat` follows `div_tap` and ignores `pwr_down`.
- R10: Further edges on the leading input while a pulse is pending keep the same pulse active until the first edge on the other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Divided reference pulse, synchronous |
| fb_in | input | 1 | Divided oscillator pulse, synchronous |
| pwr_down | input | 1 | Loop power-down request |
| test_mode | input | 1 | Selects divider view on status output |
| div_tap | input | 1 | Divided channel-counter pulse for test view |
| err_oe | output | 1 | Error output driven (0 = high-impedance) |
| err_val | output | 1 | Error output level when driven |
| out_of_lock | output | 1 | 1 while the loop is not locked |
| ps_stat | output | 1 | Power-save level or divider test view |

## Verification
The assertions assume `ref_in` and `fb_in` are already synchronous to `clk`. They also assume a new edge of the leading input never lands in the same cycle as the edge that completes a comparison, because that edge would be absorbed. The bench drives every input just after a rising clock edge and returns each pulse input to 0 before raising it again. It also lets each comparison finish and idles a few cycles before starting the next, so every edge pair it builds matches one intended phase error.

// File: rtl/lpd_pkg.sv
// Shared types for the loop phase detector.
package lpd_pkg;

    // Pending-pulse flags of the detector: up = feedback late, dn = feedback early.
    typedef struct packed {
        logic up;
        logic dn;
    } pd_flags_t;

    // Index of each pulse input inside the edge detector vector.
    localparam int EDGE_REF = 0;
    localparam int EDGE_FB  = 1;
    localparam int EDGE_NUM = 2;

endpackage

// File: rtl/lpd_edge.sv
// Rising-edge detector for a vector of synchronous pulse inputs.
// Assumes: inputs already synchronous to clk. rise is combinational,
// valid in the same cycle the input first reads 1.
module lpd_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember last level of input i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        // Edge when the level is 1 now and was 0 before.
        always_comb rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/lpd_core.sv
// Phase-frequency detector core. Sets up on a reference edge and dn on a
// feedback edge, and clears both once both are set, so the width of the
// active flag equals the phase error in cycles.
// Assumes: halt forces an idle detector.
module lpd_core
    import lpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output pd_flags_t flags,
    output logic      cmp_done
);
    logic nxt_up;
    logic nxt_dn;

    // Candidate flag values with this cycle's edges folded in.
    always_comb begin
        nxt_up   = flags.up | ref_rise;
        nxt_dn   = flags.dn | fb_rise;
        cmp_done = ~halt & nxt_up & nxt_dn;
    end

    // Flag state: cleared on reset, halt or completed comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || halt || cmp_done) begin
            flags.up <= 1'b0;
            flags.dn <= 1'b0;
        end else begin
            flags.up <= nxt_up;
            flags.dn <= nxt_dn;
        end
    end
endmodule

// File: rtl/lpd_lock.sv
// Lock monitor. Measures the error of each comparison as its pulse width,
// counts consecutive comparisons within tolerance, reports out-of-lock.
// Assumes: cmp_done is a one-cycle strobe from the detector core.
module lpd_lock #(
    parameter int WIDTH_W  = 8,
    parameter int LOCK_RUN = 4,
    parameter int LOCK_TOL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic active,
    input  logic cmp_done,
    output logic out_of_lock
);
    localparam int SW = $clog2(LOCK_RUN + 1);
    localparam logic [WIDTH_W-1:0] WMAX = {WIDTH_W{1'b1}};

    logic [WIDTH_W-1:0] width_q;
    logic [SW-1:0]      streak_q;
    logic [WIDTH_W:0]   err_w;
    logic               good;
    logic               full;

    // Error of the comparison completing this cycle.
    always_comb begin
        err_w = {1'b0, width_q} + {{WIDTH_W{1'b0}}, active};
        good  = (err_w <= (WIDTH_W+1)'(LOCK_TOL));
        full  = (streak_q == SW'(LOCK_RUN));
    end

    // Pulse width counter, saturating, restarted per comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || halt || cmp_done) width_q <= '0;
        else if (active && width_q != WMAX) width_q <= width_q + 1'b1;
    end

    // Consecutive in-tolerance comparison count.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) streak_q <= '0;
        else if (cmp_done) begin
            if (!good)      streak_q <= '0;
            else if (!full) streak_q <= streak_q + 1'b1;
        end
    end

    // Flag is high until the run is complete.
    always_comb out_of_lock = ~full;
endmodule

// File: rtl/lpd_status.sv
// Status output select: power-save level normally, divider pulse in test.
// Assumes: div_tap is synchronous to the block clock.
module lpd_status (
    input  logic test_mode,
    input  logic pwr_down,
    input  logic div_tap,
    output logic ps_stat
);
    // Pick the view requested by test_mode.
    always_comb ps_stat = test_mode ? div_tap : pwr_down;
endmodule

// File: rtl/loop_phase_det.sv
// Top of the loop phase detector: edge detection, detector core, optional
// lock monitor (LOCK_EN) and status select.
// Assumes: ref_in and fb_in synchronous to clk; synchronous active-low reset.
module loop_phase_det
    import lpd_pkg::*;
#(
    parameter bit LOCK_EN  = 1'b1,
    parameter int WIDTH_W  = 8,
    parameter int LOCK_RUN = 4,
    parameter int LOCK_TOL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pwr_down,
    input  logic test_mode,
    input  logic div_tap,
    output logic err_oe,
    output logic err_val,
    output logic out_of_lock,
    output logic ps_stat
);
    logic [EDGE_NUM-1:0] lvl;
    logic [EDGE_NUM-1:0] rise;
    pd_flags_t           flags;
    logic                cmp_done;

    // Gather the pulse inputs in edge-detector order.
    always_comb begin
        lvl[EDGE_REF] = ref_in;
        lvl[EDGE_FB]  = fb_in;
    end

    lpd_edge #(.N(EDGE_NUM)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    lpd_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (pwr_down),
        .ref_rise (rise[EDGE_REF]),
        .fb_rise  (rise[EDGE_FB]),
        .flags    (flags),
        .cmp_done (cmp_done)
    );

    // Three-state error output from the pending flags.
    always_comb begin
        err_oe  = flags.up | flags.dn;
        err_val = flags.up;
    end

    if (LOCK_EN) begin : g_lock
        lpd_lock #(
            .WIDTH_W  (WIDTH_W),
            .LOCK_RUN (LOCK_RUN),
            .LOCK_TOL (LOCK_TOL)
        ) u_lock (
            .clk         (clk),
            .rst_n       (rst_n),
            .halt        (pwr_down),
            .active      (err_oe),
            .cmp_done    (cmp_done),
            .out_of_lock (out_of_lock)
        );
    end else begin : g_nolock
        // Loop without lock monitor reports no fault.
        always_comb out_of_lock = 1'b0;
    end

    lpd_status u_status (
        .test_mode (test_mode),
        .pwr_down  (pwr_down),
        .div_tap   (div_tap),
        .ps_stat   (ps_stat)
    );
endmodule

// File: rtl/lpd_checker.sv
// Property checker for loop_phase_det, attached by bind.
module lpd_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_in,
    input logic fb_in,
    input logic pwr_down,
    input logic err_oe,
    input logic err_val,
    input logic out_of_lock
);
    AST_LATE_FB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_oe && !pwr_down && $rose(ref_in) && !$rose(fb_in)) |=> (err_oe && err_val)); // R2

    AST_EARLY_FB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_oe && !pwr_down && $rose(fb_in) && !$rose(ref_in)) |=> (err_oe && !err_val)); // R3

    AST_COINCIDE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_oe && $rose(ref_in) && $rose(fb_in)) |=> !err_oe); // R4

    AST_PD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !err_oe); // R7

    AST_PD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> out_of_lock); // R7

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_oe && err_val && !pwr_down && !$rose(fb_in)) |=> (err_oe && err_val)); // R10
endmodule

bind loop_phase_det lpd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_in      (ref_in),
    .fb_in       (fb_in),
    .pwr_down    (pwr_down),
    .err_oe      (err_oe),
    .err_val     (err_val),
    .out_of_lock (out_of_lock)
);

// File: tb/loop_phase_det_test.sv
module loop_phase_det_test;
    localparam time CLK_T = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, pwr_down = 1'b0, test_mode = 1'b0, div_tap = 1'b0;
    logic err_oe, err_val, out_of_lock, ps_stat;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    loop_phase_det uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pwr_down(pwr_down), .test_mode(test_mode), .div_tap(div_tap),
        .err_oe(err_oe), .err_val(err_val), .out_of_lock(out_of_lock), .ps_stat(ps_stat)
    );

    // Advance one clock; land just after the edge.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    // One comparison; lead=1 means reference first. Checks pulse shape.
    task automatic compare(string req, bit lead, int k);
        if (lead) ref_in = 1'b1; else fb_in = 1'b1;
        for (int i = 0; i < k; i++) begin
            step();
            ref_in = 1'b0; fb_in = 1'b0;
            chk(req, "pulse active", err_oe, 1'b1);
            chk(req, "pulse level", err_val, lead);
        end
        if (lead) fb_in = 1'b1; else ref_in = 1'b1;
        step();
        ref_in = 1'b0; fb_in = 1'b0;
        chk(req, "pulse ended", err_oe, 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        chk("R1", "oe in reset", err_oe, 1'b0);
        chk("R1", "lock flag in reset", out_of_lock, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1", "oe after reset", err_oe, 1'b0);
        chk("R1", "lock flag after reset", out_of_lock, 1'b1);
    endtask

    task automatic t_late_fb();
        compare("R2", 1'b1, 1); idle(2);
        compare("R2", 1'b1, 5); idle(2);
    endtask

    task automatic t_early_fb();
        compare("R3", 1'b0, 2); idle(2);
        compare("R3", 1'b0, 6); idle(2);
    endtask

    task automatic t_coincide();
        ref_in = 1'b1; fb_in = 1'b1;
        step(); ref_in = 1'b0; fb_in = 1'b0;
        chk("R4", "coincident float", err_oe, 1'b0);
        step();
        chk("R4", "coincident float later", err_oe, 1'b0);
        idle(2);
    endtask

    task automatic t_lock();
        // Previous stream already holds some in-tolerance comparisons; break it first.
        compare("R6", 1'b1, 3); idle(1);
        chk("R6", "unlocked after big error", out_of_lock, 1'b1);
        for (int i = 0; i < 3; i++) begin compare("R5", 1'b1, 1); idle(1); end
        chk("R5", "still unlocked after 3", out_of_lock, 1'b1);
        ref_in = 1'b1; step(); ref_in = 1'b0;
        fb_in = 1'b1; step(); fb_in = 1'b0;
        chk("R5", "locked after 4th", out_of_lock, 1'b0);
        idle(1);
        ref_in = 1'b1; fb_in = 1'b1; step(); ref_in = 1'b0; fb_in = 1'b0;
        chk("R5", "zero error keeps lock", out_of_lock, 1'b0);
        idle(1);
        fb_in = 1'b1; step(); fb_in = 1'b0; step();
        ref_in = 1'b1; step(); ref_in = 1'b0;
        chk("R6", "lock lost on 2-cycle error", out_of_lock, 1'b1);
        idle(2);
    endtask

    task automatic t_pwr_down();
        for (int i = 0; i < 4; i++) begin compare("R7", 1'b1, 1); idle(1); end
        chk("R7", "locked before power-down", out_of_lock, 1'b0);
        ref_in = 1'b1; step(); ref_in = 1'b0;
        chk("R7", "pulse pending", err_oe, 1'b1);
        pwr_down = 1'b1; step();
        chk("R7", "pending pulse cleared", err_oe, 1'b0);
        chk("R7", "unlocked in power-down", out_of_lock, 1'b1);
        ref_in = 1'b1; step(); ref_in = 1'b0;
        chk("R7", "edge ignored in power-down", err_oe, 1'b0);
        step();
        pwr_down = 1'b0; step();
        chk("R7", "no residual pulse", err_oe, 1'b0);
        chk("R7", "lock not restored", out_of_lock, 1'b1);
        idle(2);
    endtask

    task automatic t_hold();
        ref_in = 1'b1; step(); ref_in = 1'b0; step();
        ref_in = 1'b1; step(); ref_in = 1'b0;
        chk("R10", "held over second ref edge", err_oe, 1'b1);
        chk("R10", "held level", err_val, 1'b1);
        step();
        fb_in = 1'b1; step(); fb_in = 1'b0;
        chk("R10", "ended by fb edge", err_oe, 1'b0);
        idle(2);
    endtask

    task automatic t_status();
        test_mode = 1'b0; pwr_down = 1'b0; div_tap = 1'b1; #1;
        chk("R8", "status low when running", ps_stat, 1'b0);
        pwr_down = 1'b1; #1;
        chk("R8", "status high in power-down", ps_stat, 1'b1);
        test_mode = 1'b1; div_tap = 1'b0; #1;
        chk("R9", "test view low", ps_stat, 1'b0);
        div_tap = 1'b1; pwr_down = 1'b0; #1;
        chk("R9", "test view high", ps_stat, 1'b1);
        test_mode = 1'b0; div_tap = 1'b0; step();
    endtask

    initial begin
        idle(3);
        t_reset();
        idle(2);
        t_late_fb();
        t_early_fb();
        t_coincide();
        t_lock();
        t_hold();
        t_pwr_down();
        t_status();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule